// File: doc/BRIEF.md
# DMA Transfer Count and Address Counter

This block keeps the two numbers that describe a direct-memory-access block transfer. The first is a transfer count. It is loaded with the negated number of items to move and steps up by one each time a bus transfer completes. The second is a bus address. It holds the next memory location and steps forward after every transfer. When the count wraps to zero, a sticky overflow flag is set. That flag withdraws the transfer request and freezes both registers until software reloads the count.

Software writes each register one byte lane at a time. All four byte lanes share one 16-bit data input, and each lane has its own write strobe. Either register can be gated onto a shared read bus. The two gated values are OR-combined, so enabling both reads returns their bitwise OR. The address register also drives a dedicated address output at all times. A mode input chooses word transfers, where the address advances by 2, or byte transfers, where it advances by 1. The count always advances by 1 in either mode.

Top module: `dma_wc_ba`

## Requirements
- R1: While rst_n is low, the count register, the address register and cnt_ovf are all zero.
- R2: Each of the strobes ld_cnt_hi, ld_cnt_lo, ld_adr_hi and ld_adr_lo writes only its own lane of data_in into its own register. The high lane is bits 15:8 and the low lane is bits 7:0. All other bits are unchanged.
- R3: A xfer_done pulse while cnt_ovf is low adds 1 to the count on the next clock edge.
- R4: When an increment takes the count from 16'hFFFF to zero, cnt_ovf is high from the next clock edge onward.
- R5: While cnt_ovf is high, xfer_done changes neither the count register nor the address register.
- R6: A write to either lane of the count register clears cnt_ovf on that clock edge. This write wins over a wrap that happens in the same cycle.
- R7: A counted transfer advances the address by 2 when byte_mode is 0 and by 1 when byte_mode is 1. The address wraps modulo 2^16.
- R8: When a lane strobe and a counted transfer occur in the same cycle, the written lane takes data_in. The other lane of that register takes the incremented value.
- R9: data_out equals (rd_cnt ? count : 0) | (rd_adr ? address : 0).
- R10: addr_out always equals the address register, whatever the values of rd_cnt and rd_adr.
- R11: xfer_req is high exactly when xfer_en is high and cnt_ovf is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| data_in | input | 16 | Shared write data for both registers |
| ld_cnt_hi | input | 1 | Write strobe for count bits 15:8 |
| ld_cnt_lo | input | 1 | Write strobe for count bits 7:0 |
| ld_adr_hi | input | 1 | Write strobe for address bits 15:8 |
| ld_adr_lo | input | 1 | Write strobe for address bits 7:0 |
| xfer_done | input | 1 | One-cycle pulse marking a completed bus transfer |
| byte_mode | input | 1 | 1: byte transfers (address step 1); 0: word transfers (address step 2) |
| xfer_en | input | 1 | Enable for the transfer request |
| rd_cnt | input | 1 | Gates the count register onto data_out |
| rd_adr | input | 1 | Gates the address register onto data_out |
| data_out | output | 16 | OR of the gated register values |
| addr_out | output | 16 | Address register, always driven |
| cnt_ovf | output | 1 | Sticky flag: the count has wrapped to zero |
| xfer_req | output | 1 | Transfer request |

## Verification
The embedded assertions check several rules on every cycle. They check that a register holds when nothing writes or steps it, that a counted transfer adds exactly one to the count, and that it adds 1 or 2 to the address according to byte_mode. They also check that the flag rises only with a zero count, that both registers freeze while the flag is set, and that a count write clears the flag. The bench scenarios cover what a single-cycle property cannot show. These are full block transfers of several lengths and start addresses in both modes, the 16'hFFFF wrap and the 16-bit address wrap, and same-cycle collisions of a write with a transfer. They also cover single-lane writes and all four readback gate combinations.

// File: rtl/dma_wc_ba_pkg.sv
package dma_wc_ba_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned N_LANE = DATA_W / LANE_W;
  localparam int unsigned N_SRC  = 2;
  localparam int unsigned SRC_CNT = 0;
  localparam int unsigned SRC_ADR = 1;
endpackage

// File: rtl/dma_lane_counter.sv
module dma_lane_counter #(
  parameter int unsigned W      = 16,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned NL    = W / LANE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  d,
  input  logic [NL-1:0] ld_lane,
  input  logic          inc_en,
  input  logic [W-1:0]  step,
  output logic [W-1:0]  q,
  output logic          wrap
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;
  logic [W-1:0] sum;
  logic         carry;

  always_comb begin
    {carry, sum} = {1'b0, q_r} + {1'b0, step};
  end

  generate
    for (genvar g = 0; g < NL; g++) begin : g_lane
      always_comb begin
        if (ld_lane[g])
          q_nxt[g*LANE_W +: LANE_W] = d[g*LANE_W +: LANE_W];
        else if (inc_en)
          q_nxt[g*LANE_W +: LANE_W] = sum[g*LANE_W +: LANE_W];
        else
          q_nxt[g*LANE_W +: LANE_W] = q_r[g*LANE_W +: LANE_W];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  assign q    = q_r;
  assign wrap = inc_en & carry;

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_lane == '0 && !inc_en) |=> $stable(q));
endmodule

// File: rtl/dma_rd_or.sv
module dma_rd_or #(
  parameter int unsigned W = 16,
  parameter int unsigned N = 2
) (
  input  logic [N-1:0][W-1:0] src,
  input  logic [N-1:0]        gate,
  output logic [W-1:0]        bus
);
  always_comb begin
    bus = '0;
    for (int i = 0; i < N; i++)
      if (gate[i]) bus = bus | src[i];
  end
endmodule

// File: rtl/dma_wc_ba.sv
module dma_wc_ba
  import dma_wc_ba_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] data_in,
  input  logic        ld_cnt_hi,
  input  logic        ld_cnt_lo,
  input  logic        ld_adr_hi,
  input  logic        ld_adr_lo,
  input  logic        xfer_done,
  input  logic        byte_mode,
  input  logic        xfer_en,
  input  logic        rd_cnt,
  input  logic        rd_adr,
  output logic [15:0] data_out,
  output logic [15:0] addr_out,
  output logic        cnt_ovf,
  output logic        xfer_req
);
  logic [DATA_W-1:0] cnt_q;
  logic [DATA_W-1:0] adr_q;
  logic [DATA_W-1:0] adr_step;
  logic              cnt_wrap;
  logic              adr_wrap;
  logic              step_en;
  logic              cnt_wr;
  logic              ovf_r;
  logic              ovf_nxt;
  logic [N_SRC-1:0][DATA_W-1:0] rd_src;
  logic [N_SRC-1:0]             rd_gate;

  assign step_en  = xfer_done & ~ovf_r;
  assign cnt_wr   = ld_cnt_hi | ld_cnt_lo;
  assign adr_step = byte_mode ? DATA_W'(1) : DATA_W'(2);

  dma_lane_counter #(.W(DATA_W), .LANE_W(LANE_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .d       (data_in),
    .ld_lane ({ld_cnt_hi, ld_cnt_lo}),
    .inc_en  (step_en),
    .step    (DATA_W'(1)),
    .q       (cnt_q),
    .wrap    (cnt_wrap)
  );

  dma_lane_counter #(.W(DATA_W), .LANE_W(LANE_W)) u_adr (
    .clk     (clk),
    .rst_n   (rst_n),
    .d       (data_in),
    .ld_lane ({ld_adr_hi, ld_adr_lo}),
    .inc_en  (step_en),
    .step    (adr_step),
    .q       (adr_q),
    .wrap    (adr_wrap)
  );

  always_comb begin
    if (cnt_wr)        ovf_nxt = 1'b0;
    else if (cnt_wrap) ovf_nxt = 1'b1;
    else               ovf_nxt = ovf_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_r <= 1'b0;
    else        ovf_r <= ovf_nxt;
  end

  assign rd_src[SRC_CNT]  = cnt_q;
  assign rd_src[SRC_ADR]  = adr_q;
  assign rd_gate[SRC_CNT] = rd_cnt;
  assign rd_gate[SRC_ADR] = rd_adr;

  dma_rd_or #(.W(DATA_W), .N(N_SRC)) u_rd (
    .src  (rd_src),
    .gate (rd_gate),
    .bus  (data_out)
  );

  assign addr_out = adr_q;
  assign cnt_ovf  = ovf_r;
  assign xfer_req = xfer_en & ~ovf_r;

  logic unused_adr_wrap;
  assign unused_adr_wrap = adr_wrap;

  assert_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !cnt_ovf && !cnt_wr) |=> cnt_q == $past(cnt_q) + 16'd1);
  assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnt_ovf) |-> cnt_q == 16'd0);
  assert_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_ovf && !cnt_wr && !ld_adr_hi && !ld_adr_lo) |=> ($stable(cnt_q) && $stable(addr_out)));
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> !cnt_ovf);
  assert_adr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !cnt_ovf && !ld_adr_hi && !ld_adr_lo) |=>
      addr_out == $past(addr_out) + ($past(byte_mode) ? 16'd1 : 16'd2));
endmodule

// File: tb/dma_wc_ba_test.sv
module dma_wc_ba_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] data_in;
  logic        ld_cnt_hi, ld_cnt_lo, ld_adr_hi, ld_adr_lo;
  logic        xfer_done, byte_mode, xfer_en, rd_cnt, rd_adr;
  logic [15:0] data_out, addr_out;
  logic        cnt_ovf, xfer_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  dma_wc_ba uut (
    .clk(clk), .rst_n(rst_n), .data_in(data_in),
    .ld_cnt_hi(ld_cnt_hi), .ld_cnt_lo(ld_cnt_lo),
    .ld_adr_hi(ld_adr_hi), .ld_adr_lo(ld_adr_lo),
    .xfer_done(xfer_done), .byte_mode(byte_mode), .xfer_en(xfer_en),
    .rd_cnt(rd_cnt), .rd_adr(rd_adr),
    .data_out(data_out), .addr_out(addr_out),
    .cnt_ovf(cnt_ovf), .xfer_req(xfer_req)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    ld_cnt_hi = 0; ld_cnt_lo = 0; ld_adr_hi = 0; ld_adr_lo = 0; xfer_done = 0;
  endtask

  task automatic read_cnt(output logic [15:0] v);
    rd_cnt = 1; rd_adr = 0; #1; v = data_out;
  endtask

  task automatic load_cnt(input logic [15:0] v);
    data_in = v; ld_cnt_hi = 1; ld_cnt_lo = 1; tick();
  endtask

  task automatic load_adr(input logic [15:0] v);
    data_in = v; ld_adr_hi = 1; ld_adr_lo = 1; tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, ec, ea;
    rst_n = 0; data_in = 0; ld_cnt_hi = 0; ld_cnt_lo = 0; ld_adr_hi = 0; ld_adr_lo = 0;
    xfer_done = 0; byte_mode = 0; xfer_en = 0; rd_cnt = 0; rd_adr = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd_cnt = 1; #1; chk("R1 cnt", data_out, 16'h0);
    chk("R1 adr", addr_out, 16'h0);
    chk("R1 ovf", {15'b0, cnt_ovf}, 16'h0);
    @(negedge clk); rst_n = 1; @(negedge clk);

    // R2 lane writes
    load_cnt(16'h1234);
    data_in = 16'hABCD; ld_cnt_lo = 1; tick();
    read_cnt(v); chk("R2 cnt lo lane", v, 16'h12CD);
    data_in = 16'h9876; ld_cnt_hi = 1; tick();
    read_cnt(v); chk("R2 cnt hi lane", v, 16'h98CD);
    load_adr(16'h4321);
    data_in = 16'h00EE; ld_adr_lo = 1; tick();
    chk("R2 adr lo lane", addr_out, 16'h43EE);
    data_in = 16'h7700; ld_adr_hi = 1; tick();
    chk("R2 adr hi lane", addr_out, 16'h77EE);

    // Sweep: full transfers, both modes, several lengths and starts
    for (int m = 0; m < 2; m++) begin
      for (int n = 1; n <= 6; n++) begin
        for (int s = 0; s < 3; s++) begin
          byte_mode = m[0];
          ea = (s == 0) ? 16'h0100 : (s == 1) ? 16'h1FFE : 16'hFFFC;
          ec = 16'h0 - 16'(n);
          load_cnt(ec); load_adr(ea);
          xfer_en = 1; #1;
          chk("R11 req while counting", {15'b0, xfer_req}, 16'h1);
          for (int k = 0; k < n; k++) begin
            xfer_done = 1; tick();
            ec = ec + 16'd1;
            ea = ea + (m[0] ? 16'd1 : 16'd2);
            read_cnt(v); chk("R3 count step", v, ec);
            chk("R7 address step", addr_out, ea);
            chk("R10 addr_out", addr_out, ea);
          end
          chk("R4 ovf after wrap", {15'b0, cnt_ovf}, 16'h1);
          chk("R11 req dropped", {15'b0, xfer_req}, 16'h0);
          xfer_done = 1; tick(); xfer_done = 1; tick();
          read_cnt(v); chk("R5 cnt frozen", v, 16'h0);
          chk("R5 adr frozen", addr_out, ea);
          xfer_en = 0; #1;
          chk("R11 req off when disabled", {15'b0, xfer_req}, 16'h0);
        end
      end
    end

    // R4 wrap from FFFF, R6 clear by single lane write
    byte_mode = 0;
    load_cnt(16'hFFFF); xfer_done = 1; tick();
    chk("R4 ovf from FFFF", {15'b0, cnt_ovf}, 16'h1);
    data_in = 16'h0080; ld_cnt_lo = 1; tick();
    chk("R6 lo write clears ovf", {15'b0, cnt_ovf}, 16'h0);
    read_cnt(v); chk("R6 count after lo write", v, 16'h0080);
    load_cnt(16'hFFFF); xfer_done = 1; tick();
    data_in = 16'hF000; ld_cnt_hi = 1; xfer_done = 1; tick();
    chk("R6 hi write clears ovf while done", {15'b0, cnt_ovf}, 16'h0);
    xfer_en = 1; #1; chk("R11 req after clear", {15'b0, xfer_req}, 16'h1);
    // write collides with wrap: write wins
    load_cnt(16'hFFFF);
    data_in = 16'h0000; ld_cnt_lo = 1; xfer_done = 1; tick();
    chk("R6 write beats wrap", {15'b0, cnt_ovf}, 16'h0);

    // R8 lane priority
    load_cnt(16'h00FF); load_adr(16'h10FE);
    data_in = 16'h5533; ld_cnt_hi = 1; ld_adr_lo = 1; xfer_done = 1; tick();
    read_cnt(v); chk("R8 cnt hi written, lo stepped", v, 16'h5500);
    chk("R8 adr lo written, hi stepped", addr_out, 16'h1133);

    // R9 readback gating
    load_cnt(16'hA0F0); load_adr(16'h0C0F);
    rd_cnt = 0; rd_adr = 0; #1; chk("R9 none", data_out, 16'h0000);
    rd_cnt = 1; rd_adr = 0; #1; chk("R9 cnt", data_out, 16'hA0F0);
    rd_cnt = 0; rd_adr = 1; #1; chk("R9 adr", data_out, 16'h0C0F);
    rd_cnt = 1; rd_adr = 1; #1; chk("R9 both OR", data_out, 16'hACFF);
    chk("R10 addr_out independent of gates", addr_out, 16'h0C0F);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule